// File: doc/BRIEF.md
# Serial memory slave with write protection and bus hold

This block is the serial front end of a byte-addressed nonvolatile memory. A host drives chip select, serial clock and serial data in; the block returns read data on a serial output with a separate output-enable that stands for the high-impedance state. All pins are sampled by the system clock through a synchronizer. The block decodes six commands: set and clear the write-enable latch, read and write the status register, and read and write the array with an auto-incrementing address.

Writes pass through a protection check. Two status bits select a protected upper slice of the 256K-byte address space. A write-protect-enable bit, combined with an active-low protect pin, locks the status register. The write-enable latch gates every write. A hold pin pauses a command in mid-transfer. While the command is held, clock and data are ignored. The hold is released only when the serial clock is back at the level it had when the hold began. The array is a behavioural memory of 2^MEM_AW bytes, indexed by the low MEM_AW bits of the 18-bit address.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the status byte reads 00h and so_oe is low.
- R2: Opcode 06h sets the write-enable latch and 04h clears it. Opcode 05h returns the status byte, which has the protect-enable bit in bit 7, the region select in bits 3:2, the latch in bit 1 and zeros elsewhere.
- R3: Opcode 03h takes three address bytes, of which only the low 18 bits count. It returns data MSB first in SPI mode 0: data in is captured on the rising SCK edge and data out changes on the falling edge. The address increments after each byte and wraps from 3FFFFh to 00000h. Storage cell = address mod 2^MEM_AW.
- R4: Opcode 02h followed by three address bytes stores each following data byte at an incrementing, wrapping address, provided the write-enable latch is set and the address is not protected.
- R5: With the write-enable latch clear, neither array writes nor status writes take effect.
- R6: Region select 00 protects nothing, 01 protects 30000h-3FFFFh, 10 protects 20000h-3FFFFh, and 11 protects the whole array. Writes to a protected address are dropped.
- R7: Opcode 01h writes the protect-enable bit (data bit 7) and the region select (data bits 3:2) when the latch is set, unless protect-enable is 1 and wp_n is low. In that case the status is locked, while array writes outside the protected region still succeed.
- R8: When chip select rises after a recognised 02h or 01h command that was not held, the write-enable latch clears.
- R9: Holding (hold_n low with cs_n low) suspends the command: SCK edges and SI during hold have no effect, and the transfer resumes where it stopped.
- R10: A hold that began with SCK low ends only when hold_n is high and SCK is low, and a hold that began with SCK high ends only when hold_n is high and SCK is high.
- R11: so_oe is low while a read-type command (03h or 05h) is held.
- R12: Raising cs_n during hold aborts the command and leaves the write-enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out, MSB first |
| so_oe | output | 1 | Drive enable for so; low means high impedance |

## Verification
The hardest state to reach is a hold released at the wrong SCK level. Reaching it needs the clock moved while the hold is active and hold_n raised at the opposite level, with a read pending. The bench drives the pins bit by bit for this. It pauses a status read with SCK low, raises SCK, releases hold_n, and checks that the output stays disabled until SCK returns low. It then checks that the status byte continues without a lost bit. A second directed case enters the hold with SCK high in the middle of a write byte and toggles junk clock edges during the hold. Random protection settings and addresses then exercise the region boundaries against a bench model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mem_hold.sv
module spi_mem_hold (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic hold_s,
  input  logic sck_s,
  output logic held
);
  logic entry_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      entry_lvl <= 1'b0;
    end else if (cs_s) begin
      held <= 1'b0;
    end else if (!held && !hold_s) begin
      held      <= 1'b1;
      entry_lvl <= sck_s;
    end else if (held && hold_s && (sck_s == entry_lvl)) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_mem_prot.sv
module spi_mem_prot #(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  input  logic              wel,
  input  logic              wpen,
  input  logic              wp_s,
  output logic              arr_ok,
  output logic              sr_ok
);
  logic in_region;

  always_comb begin
    case (bp)
      2'b00:   in_region = 1'b0;
      2'b01:   in_region = (addr[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   in_region = addr[ADDR_W-1];
      default: in_region = 1'b1;
    endcase
  end

  assign arr_ok = wel && !in_region;
  assign sr_ok  = wel && !(wpen && !wp_s);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PW = 5;
  localparam logic [PW-1:0] PIN_RST = 5'b10011;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [PW-1:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s, wp_s;
  logic sck_q, cs_q, held;
  logic sck_rise, sck_fall, cs_rise, byte_end;

  phase_e            phase;
  logic [2:0]        bitcnt;
  logic [6:0]        shreg;
  logic [7:0]        opc, rx_byte, tx, status;
  logic [1:0]        adr_cnt, bp;
  logic [ADDR_W-1:0] addr;
  logic              wel, wpen, wr_cmd;
  logic              arr_ok, sr_ok, mem_we, sr_we;

  logic [7:0] mem [DEPTH];
  logic [7:0] mem_q;

  spi_mem_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) sync_i (
    .clk(clk), .rst(rst), .d({cs_n, sck, si, hold_n, wp_n}), .q(pins_s)
  );
  assign {cs_s, sck_s, si_s, hold_s, wp_s} = pins_s;

  spi_mem_hold hold_i (
    .clk(clk), .rst(rst), .cs_s(cs_s), .hold_s(hold_s), .sck_s(sck_s), .held(held)
  );

  spi_mem_prot #(.ADDR_W(ADDR_W)) prot_i (
    .addr(addr), .bp(bp), .wel(wel), .wpen(wpen), .wp_s(wp_s),
    .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s && !sck_q && !cs_s && !held;
  assign sck_fall = !sck_s && sck_q && !cs_s && !held;
  assign cs_rise  = cs_s && !cs_q;
  assign rx_byte  = {shreg, si_s};
  assign byte_end = sck_rise && (bitcnt == 3'd7);
  assign status   = {wpen, 3'b000, bp, wel, 1'b0};
  assign mem_we   = byte_end && (phase == PH_DAT) && (opc == OP_WRITE) && arr_ok;
  assign sr_we    = byte_end && (phase == PH_DAT) && (opc == OP_WRSR) && sr_ok;

  // command decoder and status register
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_OPC;
      bitcnt  <= '0;
      shreg   <= '0;
      opc     <= '0;
      adr_cnt <= '0;
      addr    <= '0;
      wel     <= 1'b0;
      wpen    <= 1'b0;
      bp      <= '0;
      wr_cmd  <= 1'b0;
    end else if (cs_s) begin
      phase   <= PH_OPC;
      bitcnt  <= '0;
      adr_cnt <= '0;
      wr_cmd  <= 1'b0;
      if (cs_rise && !held && wr_cmd) wel <= 1'b0;
    end else if (sck_rise) begin
      bitcnt <= bitcnt + 3'd1;
      shreg  <= rx_byte[6:0];
      if (phase == PH_ADR) addr <= {addr[ADDR_W-2:0], si_s};
      if (bitcnt == 3'd7) begin
        case (phase)
          PH_OPC: begin
            opc <= rx_byte;
            case (rx_byte)
              OP_WREN: begin wel <= 1'b1; phase <= PH_IGN; end
              OP_WRDI: begin wel <= 1'b0; phase <= PH_IGN; end
              OP_RDSR: phase <= PH_DAT;
              OP_WRSR: begin phase <= PH_DAT; wr_cmd <= 1'b1; end
              OP_READ: phase <= PH_ADR;
              OP_WRITE: begin phase <= PH_ADR; wr_cmd <= 1'b1; end
              default: phase <= PH_IGN;
            endcase
          end
          PH_ADR: begin
            adr_cnt <= adr_cnt + 2'd1;
            if (adr_cnt == 2'd2) phase <= PH_DAT;
          end
          PH_DAT: begin
            if (opc == OP_READ || opc == OP_WRITE) addr <= addr + ADDR_ONE;
            if (sr_we) begin
              wpen <= rx_byte[7];
              bp   <= rx_byte[3:2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (mem_we) mem[addr[MEM_AW-1:0]] <= rx_byte;
    mem_q <= mem[addr[MEM_AW-1:0]];
  end

  // serial output path
  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= '0;
      so_oe <= 1'b0;
    end else begin
      if (sck_fall) begin
        if (bitcnt == 3'd0) tx <= (opc == OP_RDSR) ? status : mem_q;
        else                tx <= {tx[6:0], 1'b0};
      end
      so_oe <= !cs_s && !held && (phase == PH_DAT) &&
               (opc == OP_READ || opc == OP_RDSR);
    end
  end

  assign so = tx[7];
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk (
  input logic       clk,
  input logic       rst,
  input logic       so_oe,
  input logic       held,
  input logic       hold_s,
  input logic       cs_s,
  input logic       cs_rise,
  input logic       wel,
  input logic       wpen,
  input logic       wp_s,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic       sr_we
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!so_oe && !wel));
  // R5
  arr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> wel);
  // R6
  full_protect_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> (bp != 2'b11));
  // R7
  sr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sr_we |-> (wel && !(wpen && !wp_s)));
  // R10
  hold_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (held && !hold_s && !cs_s) |=> held);
  // R11
  hold_hiz_chk: assert property (@(posedge clk) disable iff (rst) held |=> !so_oe);
  // R12
  abort_keeps_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (held && cs_rise) |=> (wel == $past(wel)));
endmodule

bind spi_mem_slave spi_mem_chk chk_i (
  .clk(clk), .rst(rst), .so_oe(so_oe), .held(held), .hold_s(hold_s),
  .cs_s(cs_s), .cs_rise(cs_rise), .wel(wel), .wpen(wpen), .wp_s(wp_s),
  .bp(bp), .mem_we(mem_we), .sr_we(sr_we)
);

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;
  localparam int HALF = 8;
  localparam int MEM_AW = 10;
  localparam int DEPTH = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int total = 0, bad = 0;

  logic [7:0] mdl [DEPTH];
  bit         vld [DEPTH];
  logic [1:0] cur_bp = 2'b00;
  logic       cur_wpen = 1'b0;

  always #4 clk = ~clk;

  spi_mem_slave #(.ADDR_W(18), .MEM_AW(MEM_AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic bit prot_hit(input logic [17:0] a, input logic [1:0] b);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[17:16] == 2'b11;
      2'b10:   return a[17];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input logic wel);
    return {cur_wpen, 3'b000, cur_bp, wel, 1'b0};
  endfunction

  task automatic bit_x(input logic b, output logic r);
    si = b;
    wt(HALF);
    r = so;
    sck = 1'b1;
    wt(HALF);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] o, output logic [7:0] i);
    for (int k = 7; k >= 0; k--) bit_x(o[k], i[k]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wt(HALF);
  endtask

  task automatic cs_hi();
    wt(HALF);
    cs_n = 1'b1;
    wt(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo();
    byte_x(op, d);
    cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo();
    byte_x(8'h05, d);
    byte_x(8'h00, st);
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v, input bit wren);
    logic [7:0] d;
    if (wren) cmd1(8'h06);
    cs_lo();
    byte_x(8'h01, d);
    byte_x(v, d);
    cs_hi();
    if (wren && !(cur_wpen && !wp_n)) begin
      cur_wpen = v[7];
      cur_bp   = v[3:2];
    end
  endtask

  task automatic send_addr(input logic [17:0] a);
    logic [7:0] d;
    byte_x({6'h2a, a[17:16]}, d);
    byte_x(a[15:8], d);
    byte_x(a[7:0], d);
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] seed, input int n, input bit wren);
    logic [7:0] d;
    logic [17:0] p;
    if (wren) cmd1(8'h06);
    cs_lo();
    byte_x(8'h02, d);
    send_addr(a);
    p = a;
    for (int k = 0; k < n; k++) begin
      byte_x(seed + 8'(k * 37), d);
      if (wren && !prot_hit(p, cur_bp)) begin
        mdl[p[MEM_AW-1:0]] = seed + 8'(k * 37);
        vld[p[MEM_AW-1:0]] = 1'b1;
      end
      p = p + 18'd1;
    end
    cs_hi();
  endtask

  task automatic rd_chk(input string req, input logic [17:0] a, input int n);
    logic [7:0] d;
    logic [17:0] p;
    cs_lo();
    byte_x(8'h03, d);
    send_addr(a);
    p = a;
    for (int k = 0; k < n; k++) begin
      byte_x(8'h00, d);
      if (vld[p[MEM_AW-1:0]]) chk(req, d, mdl[p[MEM_AW-1:0]]);
      p = p + 18'd1;
    end
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] st, d;
    logic r;
    void'($urandom(32'd2024));
    wt(5);
    rst = 1'b0;
    wt(5);

    // R1 reset state
    chk("R1 so_oe", so_oe, 1'b0);
    rdsr(st);
    chk("R1 status", st, 8'h00);

    // R2 latch set and clear
    cmd1(8'h06);
    rdsr(st);
    chk("R2 wren", st, exp_status(1'b1));
    cmd1(8'h04);
    rdsr(st);
    chk("R2 wrdi", st, exp_status(1'b0));

    // R5 write without latch
    wr(18'h00100, 8'h11, 1, 1'b1);
    wr(18'h00100, 8'h99, 1, 1'b0);
    rd_chk("R5 array", 18'h00100, 1);
    wrsr(8'h0c, 1'b0);
    rdsr(st);
    chk("R5 status", st, 8'h00);

    // R4 R3 multi-byte write and read with wrap
    wr(18'h3fffe, 8'h40, 4, 1'b1);
    rd_chk("R3 R4 wrap", 18'h3fffe, 4);
    rd_chk("R3 upper addr bits ignored", 18'h3fffe, 2);

    // R8 latch cleared after write
    rdsr(st);
    chk("R8 after write", st, 8'h00);

    // R6 boundaries for every region setting
    for (int b = 1; b < 4; b++) begin
      wrsr({4'h0, 2'(b), 2'b00}, 1'b1);
      rdsr(st);
      chk("R6 R8 status", st, exp_status(1'b0));
      wr(18'h2ffff, 8'h20 + 8'(b), 1, 1'b1);
      rd_chk("R6 below 30000", 18'h2ffff, 1);
      wr(18'h30000, 8'h30 + 8'(b), 1, 1'b1);
      rd_chk("R6 at 30000", 18'h30000, 1);
      wr(18'h1ffff, 8'h50 + 8'(b), 1, 1'b1);
      rd_chk("R6 below 20000", 18'h1ffff, 1);
      wr(18'h20000, 8'h60 + 8'(b), 1, 1'b1);
      rd_chk("R6 at 20000", 18'h20000, 1);
      wr(18'h00005, 8'h70 + 8'(b), 1, 1'b1);
      rd_chk("R6 low", 18'h00005, 1);
    end

    // R7 status lock by protect-enable and pin
    wrsr(8'h84, 1'b1);
    rdsr(st);
    chk("R7 wpen set", st, 8'h84);
    wp_n = 1'b0;
    wrsr(8'h00, 1'b1);
    rdsr(st);
    chk("R7 locked", st, 8'h84);
    wr(18'h00010, 8'h5a, 1, 1'b1);
    rd_chk("R7 array still writable", 18'h00010, 1);
    wp_n = 1'b1;
    wrsr(8'h00, 1'b1);
    rdsr(st);
    chk("R7 unlocked", st, 8'h00);

    // R9 R10 hold with SCK high in mid write byte
    cmd1(8'h06);
    cs_lo();
    byte_x(8'h02, d);
    send_addr(18'h00200);
    for (int k = 7; k >= 4; k--) bit_x(1'(8'hc3 >> k), r);
    si = 1'b0;
    wt(HALF);
    sck = 1'b1;
    wt(HALF);
    hold_n = 1'b0;
    wt(HALF);
    for (int k = 0; k < 3; k++) begin
      si = 1'(k);
      sck = 1'b0; wt(HALF);
      sck = 1'b1; wt(HALF);
    end
    sck = 1'b0;
    wt(HALF);
    hold_n = 1'b1;
    wt(2 * HALF);
    sck = 1'b1;
    wt(HALF);
    sck = 1'b0;
    for (int k = 2; k >= 0; k--) bit_x(1'(8'hc3 >> k), r);
    cs_hi();
    mdl[10'h200] = 8'hc3;
    vld[10'h200] = 1'b1;
    rd_chk("R9 R10 resume after high-level hold", 18'h00200, 1);

    // R10 R11 hold with SCK low during status read
    cmd1(8'h06);
    cs_lo();
    byte_x(8'h05, d);
    wt(HALF);
    chk("R11 read enabled", so_oe, 1'b1);
    hold_n = 1'b0;
    wt(HALF);
    chk("R11 hiz in hold", so_oe, 1'b0);
    sck = 1'b1;
    wt(HALF);
    hold_n = 1'b1;
    wt(2 * HALF);
    chk("R10 wrong level keeps hold", so_oe, 1'b0);
    sck = 1'b0;
    wt(HALF);
    chk("R10 release at entry level", so_oe, 1'b1);
    byte_x(8'h00, st);
    chk("R9 status intact", st, exp_status(1'b1));
    cs_hi();

    // R12 abort during hold before opcode recognised
    cmd1(8'h04);
    cs_lo();
    for (int k = 7; k >= 4; k--) bit_x(1'(8'h06 >> k), r);
    hold_n = 1'b0;
    wt(HALF);
    cs_n = 1'b1;
    wt(HALF);
    hold_n = 1'b1;
    wt(2 * HALF);
    rdsr(st);
    chk("R12 wel stays clear", st, exp_status(1'b0));

    // R12 abort during hold after write opcode
    cmd1(8'h06);
    cs_lo();
    byte_x(8'h02, d);
    send_addr(18'h00300);
    hold_n = 1'b0;
    wt(HALF);
    cs_n = 1'b1;
    wt(HALF);
    hold_n = 1'b1;
    wt(2 * HALF);
    rdsr(st);
    chk("R12 wel stays set", st, exp_status(1'b1));
    cmd1(8'h04);

    // R3 R4 R6 random region settings and addresses
    for (int it = 0; it < 20; it++) begin
      logic [17:0] a;
      logic [1:0] b;
      int n;
      b = 2'($urandom_range(0, 3));
      a = 18'($urandom);
      if ($urandom_range(0, 3) == 0) a = 18'h2fffe + 18'($urandom_range(0, 3));
      n = $urandom_range(1, 3);
      wrsr({4'h0, b, 2'b00}, 1'b1);
      wr(a, 8'($urandom), n, 1'b1);
      rd_chk("R3 R4 R6 random", a, n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule